// File: doc/BRIEF.md
# Toggle-Based Cross-Domain Pulse Synchronizer

This block moves single-cycle event pulses from one clock domain into another clock domain that has no fixed relation to the first. On the source side, a one-bit flag changes level each time an event is accepted. On the destination side, that level passes through a short chain of flip-flops. An edge detector at the end of the chain turns every change of level into a pulse one destination cycle wide.

The source flag is not loaded from its own previous value. It is loaded with the inverse of the first destination flip-flop, which feeds back into the source domain. The effect is that a second event arriving before the first destination stage has caught the previous change leaves the flag unchanged, so the two events come out as one pulse.

Two parameters shape the block. `SYNC_STAGES` sets the chain depth to 2 or 3; the deeper chain suits fast destination clocks. `REG_OUT` selects whether the edge detector drives the output directly or through a flip-flop. A single active-low reset is asserted asynchronously and is released separately, in step with each of the two clocks.

Top module: `pulse_xdom_sync`

## Requirements
- R1: While `rst_n` is low, `dst_pulse` is 0, and a `src_pulse` driven high during reset produces no output pulse after release.
- R2: With `src_pulse` held low, the source flag keeps its value and `dst_pulse` stays 0.
- R3: `dst_pulse` is first seen high after the (SYNC_STAGES-1+REG_OUT)-th destination rising edge that follows the source rising edge sampling `src_pulse` high. For (2,0) this is 1 edge, for (2,1) it is 2 edges and for (3,1) it is 3 edges.
- R4: At the same depth, REG_OUT=1 delays the output by exactly one destination cycle compared with REG_OUT=0.
- R5: `dst_pulse` is never high in two consecutive destination cycles when source events respect the spacing of R6.
- R6: Source events spaced at least (SYNC_STAGES+1) destination periods plus 2 source periods apart each produce exactly one output pulse.
- R7: An event sampled while the first destination stage does not yet match the source flag leaves the flag unchanged. Two events sampled within one destination period produce one output pulse.
- R8: A reset asserted while a flag change is still in flight clears it: no output pulse appears after release, and the next event is carried normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| dst_clk | input | 1 | Destination domain clock |
| rst_n | input | 1 | Shared reset, active low, asserted asynchronously |
| src_pulse | input | 1 | Event pulse, sampled on `src_clk` |
| dst_pulse | output | 1 | One-cycle event pulse, in the `dst_clk` domain |

## Verification
The source clock runs at 50 MHz and the destination clock has a 57 ns period. Neither clock is a multiple of the other, and their edges never coincide. Three configurations, (2,0), (2,1) and (3,1), are driven with the same stimulus. Widely spaced single events measure the exact latency in destination edges, which separates chain depth from output registering. A run of events at the minimum legal spacing tests whether pulses are lost or stuck together. A two-cycle source pulse that falls inside one destination period distinguishes merging, which is correct, from a flag that toggles back and yields two outputs. Events driven during reset, and a reset that cuts a flag change in flight, show that the reset clears all state both on the source side and on the destination side.

// File: rtl/pxs_pkg.sv
`timescale 1ns/1ps
package pxs_pkg;
  // depth of the reset-release synchronizers in both domains
  localparam int RST_SYNC_DEPTH = 2;
endpackage

// File: rtl/pxs_rst_release.sv
`timescale 1ns/1ps
module pxs_rst_release #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [DEPTH-1:0] shift_q;
  logic [DEPTH-1:0] shift_nxt;

  always_comb begin
    shift_nxt = {shift_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shift_q <= '0;
    else         shift_q <= shift_nxt;
  end

  assign rst_n_sync = shift_q[DEPTH-1];
endmodule

// File: rtl/pxs_src_toggle.sv
`timescale 1ns/1ps
module pxs_src_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_i,
  input  logic loop_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_nxt;
  logic load_en;

  always_comb begin
    load_en  = pulse_i;
    flag_nxt = ~loop_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (load_en) flag_q <= flag_nxt;
  end

  assign flag_o = flag_q;

  // R2: no event, no change of the flag
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_i |=> $stable(flag_q));

  // R7: an event while a change is still pending is absorbed
  p_merge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_i && (flag_q != loop_i)) |=> $stable(flag_q));
endmodule

// File: rtl/pxs_dst_chain.sv
`timescale 1ns/1ps
module pxs_dst_chain #(
  parameter int STAGES  = 2,
  parameter int REG_OUT = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_i,
  output logic first_o,
  output logic pulse_o
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_nxt;
  logic              edge_c;

  always_comb begin
    stage_nxt = {stage_q[STAGES-2:0], flag_i};
    edge_c    = stage_q[STAGES-1] ^ stage_q[STAGES-2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_nxt;
  end

  // the single first-stage flop feeds both the chain and the loopback
  assign first_o = stage_q[0];

  if (REG_OUT != 0) begin : g_reg_out
    logic out_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q <= 1'b0;
      else        out_q <= edge_c;
    end
    assign pulse_o = out_q;
  end else begin : g_comb_out
    assign pulse_o = edge_c;
  end

  // R5: output pulses are one destination cycle wide
  p_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);

  // R6: with legal spacing at most one level change is in flight
  p_one_flight_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(stage_q ^ stage_nxt) <= 1);
endmodule

// File: rtl/pulse_xdom_sync.sv
`timescale 1ns/1ps
module pulse_xdom_sync #(
  parameter int SYNC_STAGES = 2,
  parameter int REG_OUT     = 0
) (
  input  logic src_clk,
  input  logic dst_clk,
  input  logic rst_n,
  input  logic src_pulse,
  output logic dst_pulse
);
  import pxs_pkg::*;

  logic src_rst_n;
  logic dst_rst_n;
  logic flag;
  logic first_stage;

  pxs_rst_release #(.DEPTH(RST_SYNC_DEPTH)) i_src_rst (
    .clk        (src_clk),
    .arst_n     (rst_n),
    .rst_n_sync (src_rst_n)
  );

  pxs_rst_release #(.DEPTH(RST_SYNC_DEPTH)) i_dst_rst (
    .clk        (dst_clk),
    .arst_n     (rst_n),
    .rst_n_sync (dst_rst_n)
  );

  pxs_src_toggle i_src (
    .clk     (src_clk),
    .rst_n   (src_rst_n),
    .pulse_i (src_pulse),
    .loop_i  (first_stage),
    .flag_o  (flag)
  );

  pxs_dst_chain #(.STAGES(SYNC_STAGES), .REG_OUT(REG_OUT)) i_dst (
    .clk     (dst_clk),
    .rst_n   (dst_rst_n),
    .flag_i  (flag),
    .first_o (first_stage),
    .pulse_o (dst_pulse)
  );

  // R1: no output while the destination side is held in reset
  p_reset_quiet_r1: assert property (@(posedge dst_clk)
    !dst_rst_n |-> !dst_pulse);
endmodule

// File: tb/test_pulse_xdom_sync.sv
`timescale 1ns/1ps
module test_pulse_xdom_sync;
  logic sclk  = 1'b0;
  logic dclk  = 1'b0;
  logic rst_n = 1'b0;
  logic pin   = 1'b0;
  wire  [2:0] pout;

  int compared   = 0;
  int mismatched = 0;
  int dcount     = 0;
  int launch_cnt = 0;
  int npulse [3];
  int lat    [3];
  int consec [3];
  int exp_lat [3] = '{1, 2, 3};
  logic [2:0] prev = 3'b000;

  always #10 sclk = ~sclk;
  initial begin
    #0.3;
    forever #28.5 dclk = ~dclk;
  end

  pulse_xdom_sync #(.SYNC_STAGES(2), .REG_OUT(0)) i_pulse_xdom_sync (
    .src_clk(sclk), .dst_clk(dclk), .rst_n(rst_n), .src_pulse(pin), .dst_pulse(pout[0]));
  pulse_xdom_sync #(.SYNC_STAGES(2), .REG_OUT(1)) i_pulse_xdom_sync_r (
    .src_clk(sclk), .dst_clk(dclk), .rst_n(rst_n), .src_pulse(pin), .dst_pulse(pout[1]));
  pulse_xdom_sync #(.SYNC_STAGES(3), .REG_OUT(1)) i_pulse_xdom_sync_d (
    .src_clk(sclk), .dst_clk(dclk), .rst_n(rst_n), .src_pulse(pin), .dst_pulse(pout[2]));

  always @(posedge dclk) dcount <= dcount + 1;

  always @(negedge dclk) begin
    for (int i = 0; i < 3; i++) begin
      if (pout[i]) begin
        npulse[i]++;
        if (prev[i]) consec[i]++;
        else         lat[i] = dcount - launch_cnt;
      end
    end
    prev = pout;
  end

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_counts();
    for (int i = 0; i < 3; i++) begin
      npulse[i] = 0;
      lat[i]    = -1;
    end
  endtask

  task automatic wait_dst(input int n);
    repeat (n) @(negedge dclk);
  endtask

  task automatic fire();
    @(negedge sclk) pin = 1'b1;
    @(posedge sclk) launch_cnt = dcount;
    @(negedge sclk) pin = 1'b0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 3; i++) consec[i] = 0;
    clear_counts();
    repeat (3) @(negedge sclk);
    pin = 1'b1;
    repeat (3) @(negedge sclk);
    pin = 1'b0;
    wait_dst(2);
    for (int i = 0; i < 3; i++) check($sformatf("R1 out during reset inst%0d", i), pout[i], 0);
    @(negedge sclk) rst_n = 1'b1;
    wait_dst(10);
    for (int i = 0; i < 3; i++) check($sformatf("R1 no pulse from reset-time input inst%0d", i), npulse[i], 0);
    wait_dst(20);
    for (int i = 0; i < 3; i++) check($sformatf("R2 idle input stays quiet inst%0d", i), npulse[i], 0);
  endtask

  task automatic t_spaced();
    for (int k = 0; k < 4; k++) begin
      clear_counts();
      fire();
      wait_dst(8);
      for (int i = 0; i < 3; i++) begin
        check($sformatf("R6 one pulse per event k%0d inst%0d", k, i), npulse[i], 1);
        check($sformatf("R3 latency k%0d inst%0d", k, i), lat[i], exp_lat[i]);
      end
      check($sformatf("R4 registered output one cycle later k%0d", k), lat[1] - lat[0], 1);
    end
  endtask

  task automatic t_min_spacing();
    clear_counts();
    for (int k = 0; k < 6; k++) begin
      fire();
      repeat (12) @(negedge sclk);
    end
    wait_dst(8);
    for (int i = 0; i < 3; i++) check($sformatf("R6 minimum spacing count inst%0d", i), npulse[i], 6);
  endtask

  task automatic t_merge();
    clear_counts();
    @(posedge dclk);
    @(negedge sclk) pin = 1'b1;
    repeat (2) @(negedge sclk);
    pin = 1'b0;
    wait_dst(8);
    for (int i = 0; i < 3; i++) check($sformatf("R7 two events merged inst%0d", i), npulse[i], 1);
  endtask

  task automatic t_reset_pending();
    @(negedge sclk) pin = 1'b1;
    @(posedge sclk);
    #1;
    rst_n = 1'b0;
    pin   = 1'b0;
    wait_dst(5);
    for (int i = 0; i < 3; i++) check($sformatf("R8 out held low in reset inst%0d", i), pout[i], 0);
    clear_counts();
    @(negedge sclk) rst_n = 1'b1;
    wait_dst(10);
    for (int i = 0; i < 3; i++) check($sformatf("R8 in-flight change cleared inst%0d", i), npulse[i], 0);
    clear_counts();
    fire();
    wait_dst(8);
    for (int i = 0; i < 3; i++) begin
      check($sformatf("R8 event after reset carried inst%0d", i), npulse[i], 1);
      check($sformatf("R3 latency after reset inst%0d", i), lat[i], exp_lat[i]);
    end
  endtask

  initial begin
    #200000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    t_reset();
    t_spaced();
    t_min_spacing();
    t_merge();
    t_reset_pending();
    for (int i = 0; i < 3; i++) check($sformatf("R5 no back-to-back output inst%0d", i), consec[i], 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule